// File: doc/BRIEF.md
# PPS-Referenced Reference Oscillator Calibrator

This block measures how fast the local reference oscillator really runs. It uses an external one-pulse-per-second timing signal as the time base. A counter clocked by the reference runs without stopping, and its value is captured at every rising edge of the timing pulse. The difference between two captures in a row is the number of reference cycles in one second. A single such interval carries tens of nanoseconds of edge jitter. The block therefore keeps a running sum of the most recent accepted intervals, and the host reads that sum as a long-term estimate of the reference frequency.

An interval far from the nominal count points to a missing or glitched pulse. Such an interval is discarded and noted in a sticky flag. If the pulse stops arriving, a loss flag goes up and the estimate is held. When the pulse comes back, its first edge only restarts the measurement. The host reads the sum, the number of samples in the window and the status flags through its own register access path. It divides the sum by the window length to get the frequency.

Top module: `ref_cal_top`

## Requirements
- R1: After reset, `avg_sum` is 0, `sample_count` is 0, and `sum_valid`, `reject_seen` and `pps_lost` are all low.
- R2: `pps_in` is resynchronised through two flops. Each low-to-high transition counts as one edge, however long the input then stays high.
- R3: A sample is the number of `clk` cycles between two consecutive detected edges, taken modulo 2^CNT_W. The first edge after reset, and the first edge after a loss, produce no sample and only arm the measurement.
- R4: A sample is accepted when it lies in the inclusive range NOMINAL-TOL to NOMINAL+TOL. The bench uses NOMINAL=1000 and TOL=20, so 980 and 1020 are accepted and 979 and 1021 are not.
- R5: A sample outside that range leaves `avg_sum` and `sample_count` unchanged. It sets `reject_seen`, which stays high until reset.
- R6: `avg_sum` equals the sum of the last 2^WIN_LOG2 accepted samples, or of all accepted samples while fewer than that have been taken. Each new sample displaces the oldest one.
- R7: `sample_count` is the number of accepted samples, capped at 2^WIN_LOG2. It rises by one per accepted sample. `sum_valid` is high exactly when the window is full.
- R8: `pps_lost` rises once TIMEOUT cycles pass after an edge without a further edge. An edge that comes exactly TIMEOUT cycles after the previous one does not raise the flag.
- R9: While `pps_lost` is high, `avg_sum` and `sample_count` do not change. The next edge clears `pps_lost` and only re-arms the measurement. The window contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pps_in | input | 1 | External one-pulse-per-second timing input, asynchronous |
| avg_sum | output | CNT_W+WIN_LOG2 | Running sum of the accepted one-second samples |
| sample_count | output | WIN_LOG2+1 | Number of samples in the window |
| sum_valid | output | 1 | Window has filled at least once |
| reject_seen | output | 1 | Sticky: an out-of-range interval was discarded |
| pps_lost | output | 1 | No edge within TIMEOUT cycles; the estimate is held |

## Verification
Two functions can fall in the same cycle: the timeout expiry and the arrival of an edge. They coincide when an edge comes exactly TIMEOUT cycles after the previous one. The bench places pulses at exact cycle spacings to create this case. It spaces one interval at TIMEOUT, where the edge must win: `pps_lost` stays low and the interval is judged by the range rule. It spaces the next at TIMEOUT+1, where the loss must win: no rejection is recorded and the next edge only re-arms. A second overlap is a window-full sample, which adds the new value and removes the oldest in the same update. The bench's reference queue checks this across many random intervals.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int unsigned CAL_CNT_W_DEF   = 32;
  localparam int unsigned CAL_NOMINAL_DEF = 10_000_000;
  localparam int unsigned CAL_TOL_DEF     = 1000;
  localparam int unsigned CAL_TIMEOUT_DEF = 15_000_000;
  localparam int unsigned CAL_WINLOG_DEF  = 7;

  typedef enum logic {
    ARM_IDLE = 1'b0,
    ARM_RUN  = 1'b1
  } arm_state_e;

endpackage

// File: rtl/cal_pps_sync.sv
module cal_pps_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_in,
  output logic rise
);

  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pps_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;

endmodule

// File: rtl/cal_interval.sv
module cal_interval
  import cal_pkg::*;
#(
  parameter int unsigned CNT_W   = CAL_CNT_W_DEF,
  parameter int unsigned NOMINAL = CAL_NOMINAL_DEF,
  parameter int unsigned TOL     = CAL_TOL_DEF,
  parameter int unsigned TIMEOUT = CAL_TIMEOUT_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise,
  output logic             samp_vld,
  output logic [CNT_W-1:0] samp_val,
  output logic             reject_seen,
  output logic             lost
);

  localparam int unsigned TMR_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] LO_LIM = CNT_W'(NOMINAL - TOL);
  localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(NOMINAL + TOL);
  localparam logic [TMR_W-1:0] TMR_END = TMR_W'(TIMEOUT - 1);

  logic [CNT_W-1:0] free_q, free_d;
  logic [CNT_W-1:0] prev_q, prev_d;
  logic [CNT_W-1:0] val_q, val_d;
  logic [TMR_W-1:0] tmr_q, tmr_d;
  arm_state_e       arm_q, arm_d;
  logic             vld_q, vld_d;
  logic             rej_q, rej_d;
  logic             lost_q, lost_d;
  logic [CNT_W-1:0] delta;
  logic             in_rng;
  logic             expire;

  always_comb begin
    delta  = free_q - prev_q;
    in_rng = (delta >= LO_LIM) && (delta <= HI_LIM);
    expire = !rise && (tmr_q == TMR_END);

    free_d = free_q + 1'b1;
    prev_d = rise ? free_q : prev_q;
    val_d  = rise ? delta : val_q;

    if (rise)        tmr_d = '0;
    else if (expire) tmr_d = tmr_q;
    else             tmr_d = tmr_q + 1'b1;

    if (rise)        arm_d = ARM_RUN;
    else if (expire) arm_d = ARM_IDLE;
    else             arm_d = arm_q;

    if (rise)        lost_d = 1'b0;
    else if (expire) lost_d = 1'b1;
    else             lost_d = lost_q;

    vld_d = rise && (arm_q == ARM_RUN) && in_rng;
    rej_d = rej_q | (rise && (arm_q == ARM_RUN) && !in_rng);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      free_q <= '0;
      prev_q <= '0;
      val_q  <= '0;
      tmr_q  <= '0;
      arm_q  <= ARM_IDLE;
      vld_q  <= 1'b0;
      rej_q  <= 1'b0;
      lost_q <= 1'b0;
    end else begin
      free_q <= free_d;
      prev_q <= prev_d;
      val_q  <= val_d;
      tmr_q  <= tmr_d;
      arm_q  <= arm_d;
      vld_q  <= vld_d;
      rej_q  <= rej_d;
      lost_q <= lost_d;
    end
  end

  assign samp_vld    = vld_q;
  assign samp_val    = val_q;
  assign reject_seen = rej_q;
  assign lost        = lost_q;

endmodule

// File: rtl/cal_window.sv
module cal_window #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned WIN_LOG2 = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      samp_vld,
  input  logic [CNT_W-1:0]          samp_val,
  output logic [CNT_W+WIN_LOG2-1:0] sum,
  output logic [WIN_LOG2:0]         count,
  output logic                      full
);

  localparam int unsigned DEPTH = 1 << WIN_LOG2;
  localparam int unsigned SUM_W = CNT_W + WIN_LOG2;
  localparam logic [WIN_LOG2:0] CNT_FULL = (WIN_LOG2+1)'(DEPTH);

  logic [CNT_W-1:0]    mem_q [DEPTH];
  logic [WIN_LOG2-1:0] wptr_q, wptr_d;
  logic [SUM_W-1:0]    sum_q, sum_d;
  logic [WIN_LOG2:0]   cnt_q, cnt_d;
  logic                full_w;
  logic [SUM_W-1:0]    drop;

  assign full_w = (cnt_q == CNT_FULL);

  always_comb begin
    drop   = full_w ? SUM_W'(mem_q[wptr_q]) : '0;
    sum_d  = sum_q;
    cnt_d  = cnt_q;
    wptr_d = wptr_q;
    if (samp_vld) begin
      sum_d  = sum_q + SUM_W'(samp_val) - drop;
      wptr_d = wptr_q + 1'b1;
      if (!full_w) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (samp_vld) mem_q[wptr_q] <= samp_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q  <= '0;
      cnt_q  <= '0;
      wptr_q <= '0;
    end else begin
      sum_q  <= sum_d;
      cnt_q  <= cnt_d;
      wptr_q <= wptr_d;
    end
  end

  assign sum   = sum_q;
  assign count = cnt_q;
  assign full  = full_w;

endmodule

// File: rtl/ref_cal_top.sv
module ref_cal_top
  import cal_pkg::*;
#(
  parameter int unsigned CNT_W    = CAL_CNT_W_DEF,
  parameter int unsigned NOMINAL  = CAL_NOMINAL_DEF,
  parameter int unsigned TOL      = CAL_TOL_DEF,
  parameter int unsigned TIMEOUT  = CAL_TIMEOUT_DEF,
  parameter int unsigned WIN_LOG2 = CAL_WINLOG_DEF
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      pps_in,
  output logic [CNT_W+WIN_LOG2-1:0] avg_sum,
  output logic [WIN_LOG2:0]         sample_count,
  output logic                      sum_valid,
  output logic                      reject_seen,
  output logic                      pps_lost
);

  logic             rise;
  logic             samp_vld;
  logic [CNT_W-1:0] samp_val;

  cal_pps_sync u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pps_in (pps_in),
    .rise   (rise)
  );

  cal_interval #(
    .CNT_W   (CNT_W),
    .NOMINAL (NOMINAL),
    .TOL     (TOL),
    .TIMEOUT (TIMEOUT)
  ) u_intv (
    .clk         (clk),
    .rst_n       (rst_n),
    .rise        (rise),
    .samp_vld    (samp_vld),
    .samp_val    (samp_val),
    .reject_seen (reject_seen),
    .lost        (pps_lost)
  );

  cal_window #(
    .CNT_W    (CNT_W),
    .WIN_LOG2 (WIN_LOG2)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp_vld (samp_vld),
    .samp_val (samp_val),
    .sum      (avg_sum),
    .count    (sample_count),
    .full     (sum_valid)
  );

endmodule

// File: rtl/cal_chk.sv
module cal_chk #(
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned WIN_LOG2 = 7
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [CNT_W+WIN_LOG2-1:0] avg_sum,
  input logic [WIN_LOG2:0]         sample_count,
  input logic                      sum_valid,
  input logic                      reject_seen,
  input logic                      pps_lost
);

  localparam logic [WIN_LOG2:0] N_FULL = (WIN_LOG2+1)'(1 << WIN_LOG2);

  // R5
  reject_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_seen |=> reject_seen);

  // R7
  valid_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> (sample_count == N_FULL));

  // R7
  count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_count <= N_FULL);

  // R7
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sample_count) |-> (sample_count == $past(sample_count) + 1'b1));

  // R9
  lost_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_lost |=> ($stable(avg_sum) && $stable(sample_count)));

endmodule

bind ref_cal_top cal_chk #(
  .CNT_W    (CNT_W),
  .WIN_LOG2 (WIN_LOG2)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .avg_sum      (avg_sum),
  .sample_count (sample_count),
  .sum_valid    (sum_valid),
  .reject_seen  (reject_seen),
  .pps_lost     (pps_lost)
);

// File: tb/sim_ref_cal_top.sv
module sim_ref_cal_top;

  localparam int CNT_W = 32;
  localparam int NOM   = 1000;
  localparam int TOL   = 20;
  localparam int TMO   = 1500;
  localparam int WL    = 3;
  localparam int N     = 1 << WL;

  logic                clk;
  logic                rst_n;
  logic                pps_in;
  logic [CNT_W+WL-1:0] avg_sum;
  logic [WL:0]         sample_count;
  logic                sum_valid;
  logic                reject_seen;
  logic                pps_lost;

  int total;
  int fails;
  int q[$];
  bit armed;
  bit rej_exp;

  ref_cal_top #(
    .CNT_W    (CNT_W),
    .NOMINAL  (NOM),
    .TOL      (TOL),
    .TIMEOUT  (TMO),
    .WIN_LOG2 (WL)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .pps_in       (pps_in),
    .avg_sum      (avg_sum),
    .sample_count (sample_count),
    .sum_valid    (sum_valid),
    .reject_seen  (reject_seen),
    .pps_lost     (pps_lost)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic longint exp_sum();
    longint s = 0;
    foreach (q[i]) s += q[i];
    return s;
  endfunction

  function automatic bit in_range(int d);
    return (d >= NOM - TOL) && (d <= NOM + TOL);
  endfunction

  task automatic chk(string req, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " R6 sum"}, longint'(avg_sum), exp_sum());
    chk({req, " R7 count"}, longint'(sample_count), longint'(q.size()));
    chk({req, " R7 valid"}, longint'(sum_valid), longint'(q.size() == N));
    chk({req, " R5 reject"}, longint'(reject_seen), longint'(rej_exp));
    chk({req, " R9 lost clear"}, longint'(pps_lost), 0);
  endtask

  // R3: d is the exact cycle spacing from the previous pulse
  task automatic send(int d, int width, string req);
    if (d >= TMO + 20) begin
      repeat (d - 8 - 4) @(negedge clk);
      chk("R8 lost raised in gap", longint'(pps_lost), 1);
      repeat (4) @(negedge clk);
    end else begin
      repeat (d - 8) @(negedge clk);
    end
    pps_in = 1'b1;
    repeat (width) @(negedge clk);
    pps_in = 1'b0;
    repeat (8 - width) @(negedge clk);
    if (!armed) armed = 1'b1;
    else if (d > TMO) armed = 1'b1;
    else if (in_range(d)) begin
      q.push_back(d);
      if (q.size() > N) void'(q.pop_front());
    end else rej_exp = 1'b1;
    check_all(req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    pps_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    q.delete();
    armed = 1'b0;
    rej_exp = 1'b0;
    chk("R1 sum", longint'(avg_sum), 0);
    chk("R1 count", longint'(sample_count), 0);
    chk("R1 valid", longint'(sum_valid), 0);
    chk("R1 reject", longint'(reject_seen), 0);
    chk("R1 lost", longint'(pps_lost), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    total = 0;
    fails = 0;
    void'($urandom(32'd1234));
    do_reset();
    send(NOM, 1, "R3 arm");
    send(NOM - TOL, 1, "R4 low edge");
    send(NOM + TOL, 3, "R2 wide pulse R4 high edge");
    for (int i = 0; i < 12; i++) begin
      send(NOM - TOL + int'($urandom_range(0, 2 * TOL)), 1 + int'($urandom_range(0, 2)), "R6 random fill");
    end
    send(NOM + TOL + 1, 1, "R4 R5 above");
    send(NOM - TOL - 1, 1, "R4 R5 below");
    for (int i = 0; i < 14; i++) begin
      int d;
      if ($urandom_range(0, 5) == 0) d = NOM + TOL + 1 + int'($urandom_range(0, 60));
      else d = NOM - TOL + int'($urandom_range(0, 2 * TOL));
      send(d, 1, "R6 random mix");
    end
    send(TMO, 1, "R8 edge at timeout");
    send(TMO + 1, 1, "R8 R9 timeout wins");
    send(NOM, 1, "R9 after rearm");
    send(TMO + 200, 1, "R9 long gap");
    for (int i = 0; i < 6; i++) begin
      send(NOM - TOL + int'($urandom_range(0, 2 * TOL)), 1, "R9 resume");
    end
    do_reset();
    send(NOM, 1, "R3 arm again");
    send(NOM + 5, 1, "R3 first sample");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule